// File: doc/BRIEF.md
# Memory Region Security Filter

This block sits in front of a DRAM port and decides, for each access, whether it may proceed. Software programs eight address windows, each with a start and an end in whole megabytes, and one control word. In the control word, each window can be marked secure-only. A separate flag marks all memory outside the eight windows as secure-only. A bypass flag turns every check off.

Each access arrives with an address and a secure/non-secure attribute. One clock later the block returns a permit or a deny. Configuration writes use a masked format: the upper half of the written word selects which of the lower sixteen bits change. The rest of the chip can therefore update single bits without first reading the word.

Top module: `mem_region_filter`

## Requirements
- R1: After reset all seventeen configuration words read as zero, and every access is permitted.
- R2: A write to word n (0..16) changes only those data bits 15:0 whose enable bit in cfg_wdata[31:16] is 1. With a zero enable half, the write changes nothing.
- R3: A read returns the selected word in bits 15:0 and zero in bits 31:16. A word index above 16 reads as zero, and writes to it are ignored.
- R4: Word k (0..7) holds the start megabyte of window k, and word k+8 holds its inclusive end megabyte. An access matches window k when start ≤ acc_addr[31:20] ≤ end, so both boundary megabytes match.
- R5: Control word 16, bit k (0..7), marks window k as secure-only. A non-secure access that matches such a window is denied. A secure access is always permitted.
- R6: Control word 16, bit 8, marks the catch-all area as secure-only. The catch-all area is every address that matches none of the eight windows, whether or not the windows are enabled. Non-secure accesses there are denied while bit 8 is set.
- R7: Control word 16, bit 9, is a bypass. While it is set, every access is permitted.
- R8: When windows overlap, an address is secure-only if any enabled window that contains it is secure-only. A window whose start is greater than its end matches nothing.
- R9: chk_valid is acc_valid delayed by one cycle. chk_permit holds the decision for that access, made with the configuration in effect before any write issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 5 | Configuration word index |
| cfg_wdata | input | 32 | Write data: [31:16] bit enables, [15:0] data |
| cfg_rdata | output | 32 | Read data of the selected word (combinational) |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | 32 | Access byte address |
| acc_secure | input | 1 | 1 = secure access |
| chk_valid | output | 1 | Decision valid (one cycle after acc_valid) |
| chk_permit | output | 1 | 1 = permit, 0 = deny |

## Verification
The hardest state to reach from the ports combines three conditions. The windows overlap, a reversed window is enabled, and the catch-all flag is set, so that the window match and the catch-all rule have to be told apart. The stimulus builds this state step by step through masked writes that each set only a few bits. At every step it probes the megabytes on both sides of each boundary with both attributes. Some writes land in the same cycle as an access, which confirms that the decision uses the configuration from before the write.

// File: rtl/mem_region_filter.sv
module mem_region_filter #(
  parameter int ADDR_W   = 32,
  parameter int NREG     = 8,
  parameter int MB_SHIFT = 20,
  parameter int SEL_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_secure,
  output logic              chk_valid,
  output logic              chk_permit
);
  localparam int DATA_W = 16;
  localparam int WORDS  = 2*NREG + 1;
  localparam int MB_W   = ADDR_W - MB_SHIFT;
  localparam logic [SEL_W-1:0] CTL_IDX = SEL_W'(2*NREG);

  logic [DATA_W-1:0] cfg_q [WORDS];
  logic [DATA_W-1:0] wmask, wdat, mb;
  logic [NREG-1:0]   hit;
  logic              sel_ok, bypass, outside_sec, secure_hit, deny;

  assign sel_ok = cfg_sel <= CTL_IDX;
  assign wmask  = cfg_wdata[31:16];
  assign wdat   = cfg_wdata[15:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) cfg_q[i] <= '0;
    end else if (cfg_we && sel_ok) begin
      cfg_q[cfg_sel] <= (cfg_q[cfg_sel] & ~wmask) | (wdat & wmask);
    end
  end

  assign cfg_rdata = sel_ok ? {16'h0, cfg_q[cfg_sel]} : 32'h0;

  assign mb = DATA_W'(acc_addr[ADDR_W-1:MB_SHIFT]);

  for (genvar g = 0; g < NREG; g++) begin : g_win
    assign hit[g] = (mb >= cfg_q[g]) && (mb <= cfg_q[g+NREG]);
  end

  assign bypass      = cfg_q[2*NREG][NREG+1];
  assign outside_sec = cfg_q[2*NREG][NREG];
  assign secure_hit  = |(hit & cfg_q[2*NREG][NREG-1:0]);
  assign deny        = !bypass && !acc_secure &&
                       (secure_hit || (!(|hit) && outside_sec));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_valid  <= 1'b0;
      chk_permit <= 1'b1;
    end else begin
      chk_valid <= acc_valid;
      if (acc_valid) chk_permit <= !deny;
    end
  end
endmodule

module mem_region_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_secure,
  input logic        bypass,
  input logic        chk_valid,
  input logic        chk_permit,
  input logic [31:0] cfg_rdata
);
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> chk_valid);
  assert_idle_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !chk_valid);
  assert_secure_permit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_secure) |=> chk_permit);
  assert_bypass_permit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && bypass) |=> chk_permit);
  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:16] == 16'h0);
endmodule

bind mem_region_filter mem_region_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_secure(acc_secure),
  .bypass(bypass), .chk_valid(chk_valid), .chk_permit(chk_permit),
  .cfg_rdata(cfg_rdata)
);

// File: tb/mem_region_filter_tb.sv
module mem_region_filter_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, acc_valid = 0, acc_secure = 0;
  logic [4:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0, acc_addr = 0, cfg_rdata;
  logic chk_valid, chk_permit;

  mem_region_filter u_dut (.*);

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  logic [15:0] m [17];
  logic pend_v = 0, pend_p = 1;
  string cur = "R1", pend_req = "R1";

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic model_permit(logic [31:0] a, logic s);
    int mbv = a[31:20];
    bit any = 0, sec = 0;
    if (m[16][9] || s) return 1;
    for (int k = 0; k < 8; k++)
      if (mbv >= m[k] && mbv <= m[k+8]) begin
        any = 1;
        if (m[16][k]) sec = 1;
      end
    return !(sec || (!any && m[16][8]));
  endfunction

  task automatic step(logic we, int sel, logic [31:0] wd, logic av, logic [31:0] a, logic s);
    @(negedge clk);
    chk(pend_req, "chk_valid", chk_valid, pend_v);
    if (pend_v) chk(pend_req, "chk_permit", chk_permit, pend_p);
    cfg_we = we; cfg_sel = sel[4:0]; cfg_wdata = wd;
    acc_valid = av; acc_addr = a; acc_secure = s;
    #1;
    chk(cur, "cfg_rdata", cfg_rdata, (sel <= 16) ? {16'h0, m[sel]} : 32'h0);
    pend_v = av; pend_p = model_permit(a, s); pend_req = cur;
    if (we && sel <= 16) m[sel] = (m[sel] & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
  endtask

  task automatic wr(int sel, logic [15:0] mask, logic [15:0] d);
    step(1, sel, {mask, d}, 0, 0, 0);
  endtask
  task automatic acc(logic [31:0] a, logic s);
    step(0, 16, 0, 1, a, s);
  endtask
  task automatic rd(int sel);
    step(0, sel, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 17; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur = "R1";
    for (int i = 0; i < 17; i++) rd(i);
    acc(32'h0000_0000, 0); acc(32'h0550_0000, 0); acc(32'hFFF0_0000, 0);
    cur = "R2";
    wr(0, 16'h00FF, 16'hABCD); rd(0);
    wr(0, 16'hFF00, 16'h1200); rd(0);
    wr(0, 16'h0000, 16'hFFFF); rd(0);
    wr(0, 16'hFFFF, 16'h0002); rd(0);
    cur = "R3";
    wr(20, 16'hFFFF, 16'hFFFF); rd(20); rd(31); rd(16);
    cur = "R4";
    wr(8, 16'hFFFF, 16'h0003);
    wr(16, 16'h0001, 16'h0001);
    acc(32'h001F_FFFF, 0); acc(32'h0020_0000, 0); acc(32'h003F_FFFF, 0);
    acc(32'h0040_0000, 0);
    cur = "R5";
    acc(32'h0020_0000, 1); acc(32'h0030_0000, 1); acc(32'h0030_0000, 0);
    cur = "R6";
    wr(1, 16'hFFFF, 16'h000A); wr(9, 16'hFFFF, 16'h000A);
    wr(16, 16'h0100, 16'h0100);
    acc(32'h00A0_0000, 0); acc(32'h00B0_0000, 0); acc(32'h00B0_0000, 1);
    acc(32'h0010_0000, 0); acc(32'h0020_0000, 0);
    cur = "R7";
    wr(16, 16'h0200, 16'h0200);
    acc(32'h0020_0000, 0); acc(32'h00B0_0000, 0);
    wr(16, 16'h0200, 16'h0000);
    acc(32'h00B0_0000, 0);
    cur = "R8";
    wr(1, 16'hFFFF, 16'h0008); wr(9, 16'hFFFF, 16'h000C);
    wr(2, 16'hFFFF, 16'h000A); wr(10, 16'hFFFF, 16'h000B);
    wr(16, 16'h0004, 16'h0004);
    acc(32'h0090_0000, 0); acc(32'h00A0_0000, 0); acc(32'h00B0_0000, 0);
    acc(32'h00C0_0000, 0); acc(32'h00D0_0000, 0);
    wr(3, 16'hFFFF, 16'h0014); wr(11, 16'hFFFF, 16'h000F);
    wr(16, 16'h0008, 16'h0008);
    acc(32'h0110_0000, 0); acc(32'h0140_0000, 0);
    wr(16, 16'h0100, 16'h0000);
    acc(32'h0110_0000, 0); acc(32'h0140_0000, 0);
    cur = "R9";
    step(1, 16, 32'h0100_0100, 1, 32'h0110_0000, 0);
    acc(32'h0110_0000, 0);
    step(1, 16, 32'h0200_0200, 1, 32'h0020_0000, 0);
    step(0, 16, 0, 0, 32'h0020_0000, 0);
    acc(32'h0020_0000, 0);
    rd(16);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule